// File: doc/BRIEF.md
# Locked Configuration Port Controller

This block is a legacy byte-wide I/O configuration controller. It answers at two addresses: an index port at `PORT_BASE` and a data port at `PORT_BASE + 1`. Software writes a register index to the index port, then reads or writes that register's data through the data port.

Access is locked after reset. Two index-port writes, 0x80 followed by 0x86, unlock it. Two more, 0x68 followed by 0x08, lock it again. Once unlocked, index 0x07 selects a logical device number. The enable register and the two base-address bytes are banked per logical device. One global register sets the interrupt enable and the UART clock predivide. The block drives one enable bit and one 16-bit base address to each peripheral, plus a predivide select and an interrupt-enable line.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset the block is locked, and every register holds 0. So `dev_en`, `dev_base`, `clk_div_sel` and `irq_en` are all 0.
- R2: Two consecutive index-port writes of 0x80 and then 0x86 unlock access.
  - The matcher counts only index-port writes.
  - A wrong second byte returns the matcher to idle. That byte is not taken as a new first byte.
- R3: While unlocked, two consecutive index-port writes of 0x68 and then 0x08 lock access again.
- R4: While locked, data-port writes change nothing and data-port reads return 0xFF.
  - Index-port reads return 0xFF while locked.
  - While unlocked, an index-port read returns the last index written.
- R5: Index 0x07 is the logical-device-number register, and it reads back as written. Devices 0x04, 0x05 and 0x06 (serial port 1, serial port 2, watchdog) map to bits 0, 1 and 2 of `dev_en`.
- R6: Per-device index 0x30 bit 0 is the selected device's enable. It drives that device's `dev_en` bit and reads back as 0x00 or 0x01.
- R7: Per-device indices 0x60 and 0x61 hold the high and low bytes of the selected device's base address. Device n (counting from 0) drives `dev_base[16n+15:16n]`.
- R8: Global index 0x29 behaves as follows.
  - Bit 0 drives `irq_en`.
  - Bits [3:2] are the predivide field, with the encoding 00 = divide by 1, 01 = divide by 8, 10 = divide by 26, 11 = reserved.
  - The field drives `clk_div_sel` directly, except that 11 is kept as written and `clk_div_sel` reads 00.
  - Other bits read back as 0.
- R9: Unimplemented indices read 0x00 and ignore writes. A selected device number outside 0x04..0x06 has no per-device registers: those reads return 0x00 and writes change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational while `io_rd` is high, else 0 |
| dev_en | output | NUM_DEV | Per-device enable |
| dev_base | output | 16*NUM_DEV | Per-device I/O base addresses |
| clk_div_sel | output | 2 | UART clock predivide select |
| irq_en | output | 1 | Device interrupt enable |

## Verification
Read data is combinational, so the bench samples `io_rdata` within the cycle the read strobe is held. Every write takes effect at the single clock edge inside its one-cycle strobe. The bench drives strobes at a falling edge and samples at the next falling edge, so outputs and state changes are read half a cycle after the edge that registers them. Lock-state changes are checked the same way, through data-port reads issued after the second key byte's write has completed.

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl #(
  parameter logic [15:0] PORT_BASE = 16'h004E,
  parameter int          NUM_DEV   = 3,
  parameter logic [7:0]  FIRST_LDN = 8'h04
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [15:0]            io_addr,
  input  logic                   io_wr,
  input  logic                   io_rd,
  input  logic [7:0]             io_wdata,
  output logic [7:0]             io_rdata,
  output logic [NUM_DEV-1:0]     dev_en,
  output logic [16*NUM_DEV-1:0]  dev_base,
  output logic [1:0]             clk_div_sel,
  output logic                   irq_en
);
  localparam logic [15:0] DATA_PORT = PORT_BASE + 16'd1;

  logic       unlocked, armed;
  logic [7:0] idx, ldn, rel;
  logic [1:0] div_f;
  logic [NUM_DEV-1:0] hit;

  wire idx_wr  = io_wr && io_addr == PORT_BASE;
  wire dat_wr  = io_wr && io_addr == DATA_PORT && unlocked;
  wire [7:0] key_a = unlocked ? 8'h68 : 8'h80;
  wire [7:0] key_b = unlocked ? 8'h08 : 8'h86;

  assign rel = ldn - FIRST_LDN;
  always_comb
    for (int i = 0; i < NUM_DEV; i++)
      hit[i] = ldn >= FIRST_LDN && rel == 8'(i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      armed    <= 1'b0;
    end else if (idx_wr) begin
      if (armed) begin
        armed <= 1'b0;
        if (io_wdata == key_b) unlocked <= !unlocked;
      end else begin
        armed <= io_wdata == key_a;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx    <= 8'h00;
      ldn    <= 8'h00;
      div_f  <= 2'b00;
      irq_en <= 1'b0;
    end else begin
      if (idx_wr && unlocked) idx <= io_wdata;
      if (dat_wr && idx == 8'h07) ldn <= io_wdata;
      if (dat_wr && idx == 8'h29) begin
        div_f  <= io_wdata[3:2];
        irq_en <= io_wdata[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_en   <= '0;
      dev_base <= '0;
    end else if (dat_wr) begin
      for (int i = 0; i < NUM_DEV; i++) begin
        if (hit[i]) begin
          if (idx == 8'h30) dev_en[i] <= io_wdata[0];
          if (idx == 8'h60) dev_base[16*i+8 +: 8] <= io_wdata;
          if (idx == 8'h61) dev_base[16*i   +: 8] <= io_wdata;
        end
      end
    end
  end

  assign clk_div_sel = (div_f == 2'b11) ? 2'b00 : div_f;

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd && io_addr == PORT_BASE) begin
      io_rdata = unlocked ? idx : 8'hFF;
    end else if (io_rd && io_addr == DATA_PORT) begin
      if (!unlocked) io_rdata = 8'hFF;
      else begin
        case (idx)
          8'h07: io_rdata = ldn;
          8'h29: io_rdata = {4'h0, div_f, 1'b0, irq_en};
          default: io_rdata = 8'h00;
        endcase
        for (int i = 0; i < NUM_DEV; i++) begin
          if (hit[i]) begin
            if (idx == 8'h30) io_rdata = {7'h00, dev_en[i]};
            if (idx == 8'h60) io_rdata = dev_base[16*i+8 +: 8];
            if (idx == 8'h61) io_rdata = dev_base[16*i   +: 8];
          end
        end
      end
    end
  end
endmodule

module cfg_port_ctrl_chk #(
  parameter logic [15:0] PORT_BASE = 16'h004E,
  parameter int          NUM_DEV   = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [15:0]           io_addr,
  input logic                  io_wr,
  input logic                  io_rd,
  input logic [7:0]            io_wdata,
  input logic [7:0]            io_rdata,
  input logic [NUM_DEV-1:0]    dev_en,
  input logic [16*NUM_DEV-1:0] dev_base,
  input logic [1:0]            clk_div_sel,
  input logic                  irq_en,
  input logic                  unlocked,
  input logic                  armed
);
  p_locked_read_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && io_rd && io_addr == PORT_BASE + 16'd1) |-> io_rdata == 8'hFF);

  p_locked_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && io_wr && io_addr == PORT_BASE + 16'd1) |=>
      ($stable(dev_en) && $stable(dev_base) && $stable(clk_div_sel) && $stable(irq_en)));

  p_div_never_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_div_sel != 2'b11);

  p_unlock_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && armed && io_wr && io_addr == PORT_BASE && io_wdata == 8'h86) |=> unlocked);

  p_lock_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && armed && io_wr && io_addr == PORT_BASE && io_wdata == 8'h08) |=> !unlocked);
endmodule

bind cfg_port_ctrl cfg_port_ctrl_chk #(.PORT_BASE(PORT_BASE), .NUM_DEV(NUM_DEV)) u_chk (.*);

// File: tb/cfg_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module cfg_port_ctrl_tb_top;
  localparam logic [15:0] IDX = 16'h004E;
  localparam logic [15:0] DAT = 16'h004F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [2:0]  dev_en;
  logic [47:0] dev_base;
  logic [1:0]  clk_div_sel;
  logic        irq_en;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  cfg_port_ctrl dut_i (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
    wr(IDX, i); wr(DAT, d);
  endtask

  task automatic reg_rd(input logic [7:0] i, output logic [7:0] d);
    wr(IDX, i); rd(DAT, d);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 dev_en", dev_en, 0);
    chk("R1 dev_base", dev_base, 0);
    chk("R1 clk_div_sel", clk_div_sel, 0);
    chk("R1 irq_en", irq_en, 0);
    rd(DAT, d); chk("R1 locked read", d, 8'hFF);
  endtask

  task automatic t_locked;
    logic [7:0] d;
    wr(IDX, 8'h30); wr(DAT, 8'h01);
    chk("R4 locked write dev_en", dev_en, 0);
    wr(IDX, 8'h29); wr(DAT, 8'h0B);
    chk("R4 locked write irq_en", irq_en, 0);
    chk("R4 locked write div", clk_div_sel, 0);
    rd(DAT, d); chk("R4 locked data read", d, 8'hFF);
    rd(IDX, d); chk("R4 locked index read", d, 8'hFF);
  endtask

  task automatic t_bad_key;
    logic [7:0] d;
    wr(IDX, 8'h80); wr(IDX, 8'h80); wr(IDX, 8'h86);
    rd(DAT, d); chk("R2 repeated first byte stays locked", d, 8'hFF);
    wr(IDX, 8'h80); wr(IDX, 8'h55); wr(IDX, 8'h86);
    rd(DAT, d); chk("R2 wrong byte stays locked", d, 8'hFF);
  endtask

  task automatic t_unlock;
    logic [7:0] d;
    wr(IDX, 8'h80); wr(IDX, 8'h86);
    wr(IDX, 8'h07);
    rd(IDX, d); chk("R2 unlocked index read", d, 8'h07);
    rd(DAT, d); chk("R2 unlocked data read", d, 8'h00);
  endtask

  task automatic t_devices;
    logic [7:0] d;
    reg_wr(8'h07, 8'h04);
    reg_rd(8'h07, d); chk("R5 ldn readback", d, 8'h04);
    reg_wr(8'h30, 8'h01);
    reg_wr(8'h60, 8'h03); reg_wr(8'h61, 8'hF8);
    chk("R6 dev_en sp1", dev_en, 3'b001);
    chk("R7 dev_base sp1", dev_base[15:0], 16'h03F8);
    reg_wr(8'h07, 8'h06);
    reg_wr(8'h60, 8'h12); reg_wr(8'h61, 8'h34);
    chk("R7 dev_base wdt", dev_base[47:32], 16'h1234);
    chk("R7 dev_base sp2 untouched", dev_base[31:16], 16'h0000);
    reg_rd(8'h30, d); chk("R6 wdt enable readback", d, 8'h00);
    reg_wr(8'h07, 8'h05);
    reg_wr(8'h30, 8'hFF);
    chk("R6 dev_en sp2", dev_en, 3'b011);
    reg_rd(8'h30, d); chk("R6 sp2 enable readback", d, 8'h01);
    reg_wr(8'h07, 8'h04);
    reg_rd(8'h60, d); chk("R7 sp1 high readback", d, 8'h03);
    reg_rd(8'h61, d); chk("R7 sp1 low readback", d, 8'hF8);
  endtask

  task automatic t_global;
    logic [7:0] d;
    reg_wr(8'h29, 8'h09);
    chk("R8 div26", clk_div_sel, 2'b10);
    chk("R8 irq_en", irq_en, 1'b1);
    reg_rd(8'h29, d); chk("R8 readback 0x09", d, 8'h09);
    reg_wr(8'h29, 8'h04);
    chk("R8 div8", clk_div_sel, 2'b01);
    chk("R8 irq off", irq_en, 1'b0);
    reg_wr(8'h29, 8'hFF);
    chk("R8 reserved falls back", clk_div_sel, 2'b00);
    reg_rd(8'h29, d); chk("R8 reserved kept", d, 8'h0D);
    reg_wr(8'h29, 8'h00);
    chk("R8 div1", clk_div_sel, 2'b00);
  endtask

  task automatic t_unimpl;
    logic [7:0] d;
    reg_wr(8'h55, 8'hA5);
    reg_rd(8'h55, d); chk("R9 unimplemented index", d, 8'h00);
    reg_wr(8'h07, 8'h02);
    reg_wr(8'h30, 8'h01); reg_wr(8'h60, 8'hAA);
    chk("R9 bad ldn dev_en", dev_en, 3'b011);
    chk("R9 bad ldn dev_base", dev_base, {16'h1234, 16'h0000, 16'h03F8});
    reg_rd(8'h60, d); chk("R9 bad ldn read", d, 8'h00);
  endtask

  task automatic t_relock;
    logic [7:0] d;
    reg_wr(8'h07, 8'h04);
    wr(IDX, 8'h68); wr(IDX, 8'h08);
    rd(DAT, d); chk("R3 relocked read", d, 8'hFF);
    wr(IDX, 8'h30); wr(DAT, 8'h00);
    chk("R3 relocked write ignored", dev_en, 3'b011);
    wr(IDX, 8'h80); wr(IDX, 8'h86);
    reg_rd(8'h61, d); chk("R3 state kept across lock", d, 8'hF8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_locked;
    t_bad_key;
    t_unlock;
    t_devices;
    t_global;
    t_unimpl;
    t_relock;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule